// File: doc/BRIEF.md
# Processor Powerdown Sequencer

This block takes a processor core from normal execution into a low-power state and brings it back. Software starts the sequence by writing 1 to the powerdown-request bits. The block then raises a powerdown interrupt request that cannot be masked and presents a fixed vector with it. Once the interrupt controller takes the request, the core runs housekeeping code. The clocks stop only when the core reports an idle instruction while the request is still pending.

Two events abort the sequence before idle: a rising edge on the power-up bit, or a return-from-interrupt during housekeeping. While the core is powered down, the block keeps the core clock and the PLL off and asserts an output-hold signal. A crystal-force-on option keeps the oscillator running during powerdown.

A rising edge on the power-up bit starts the wake-up. If the oscillator was stopped, the block first waits for it to settle. It then waits for PLL lock before it enables the clocks again. On the first cycle with clocks running it pulses either a resume signal or a context-clear signal, chosen by a start-up mode input.

Top module: `pwrdn_seq`

## Requirements
- R1: After reset, `phase_o` is 0 (running), `clk_en_o`, `osc_en_o` and `pll_en_o` are 1, and `nmi_req_o`, `hold_o`, `ctx_clr_o` and `resume_o` are 0.
- R2: A `pd_set_i` strobe in the running phase sets `phase_o` to 1 (interrupt pending) on the next cycle, with `nmi_req_o`=1 and `nmi_vec_o`=0x002C. The block has no masking input. The request stays high until `irq_ack_i` arrives.
- R3: `irq_ack_i` in phase 1 moves the block to phase 2 (housekeeping) and drops `nmi_req_o` on the next cycle.
- R4: A `pd_set_i` strobe in phase 1 or phase 2 is ignored. The phase is unchanged and no new interrupt request is raised.
- R5: `idle_i` in phase 2 gates the clocks one cycle later. `phase_o` becomes 3 (powered down), with `clk_en_o`=0, `pll_en_o`=0 and `hold_o`=1. `idle_i` in phase 0 or phase 1 has no effect.
- R6: A 0-to-1 change of `pu_bit_i` in phase 1 or phase 2 aborts the sequence. The block returns to phase 0 on the next cycle with `nmi_req_o`=0. This abort takes priority over `idle_i` in the same cycle.
- R7: `rti_i` in phase 2 aborts the sequence and returns the block to phase 0 on the next cycle.
- R8: In phase 3, `osc_en_o` follows `xtal_on_i`. `idle_i`, `rti_i`, `pd_set_i` and a `pu_bit_i` that stays high have no effect there.
- R9: A 0-to-1 change of `pu_bit_i` in phase 3 moves the block to phase 4 (waking) on the next cycle, with `osc_en_o`=1, `pll_en_o`=1, `clk_en_o`=0 and `hold_o`=1.
- R10: Phase 4 ends only when `pll_lock_i` is 1 and the oscillator wait has expired. The wait is 0 cycles if `xtal_on_i` was 1 at wake-up and OSC_CYC cycles otherwise. With the lock held high, phase 4 therefore lasts 1 or OSC_CYC+1 cycles.
- R11: In the first cycle after phase 4 returns to phase 0, `ctx_clr_o` pulses for one cycle if `ctx_mode_i`=1, and `resume_o` pulses for one cycle if `ctx_mode_i`=0. The two pulses never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_set_i | input | 1 | One-cycle strobe: 1 written to the powerdown-request bits |
| pu_bit_i | input | 1 | Level of the power-up bit |
| irq_ack_i | input | 1 | Interrupt controller has taken the powerdown vector |
| rti_i | input | 1 | Return-from-interrupt executed |
| idle_i | input | 1 | Idle instruction executed |
| pll_lock_i | input | 1 | PLL reports stable output |
| xtal_on_i | input | 1 | Crystal-force-on option |
| ctx_mode_i | input | 1 | Start-up mode: 1 clears context, 0 resumes |
| nmi_req_o | output | 1 | Non-maskable powerdown interrupt request |
| nmi_vec_o | output | VEC_W | Vector address of the powerdown interrupt |
| clk_en_o | output | 1 | Core clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| hold_o | output | 1 | Hold core outputs and state |
| ctx_clr_o | output | 1 | One-cycle context-clear pulse on wake |
| resume_o | output | 1 | One-cycle resume pulse on wake |
| phase_o | output | 3 | Phase: 0 run, 1 pending, 2 housekeeping, 3 down, 4 waking |

## Verification
The assertions take every control input as synchronous to `clk` and single-cycle where it is a strobe. They expect `irq_ack_i` only while a request is pending, and they take `pll_lock_i` as meaningful only while the PLL is enabled. The directed stimulus drives all inputs just after the falling edge, one pulse wide. It raises the acknowledge only in phase 1. It holds the lock high during wake-up except in the scenario that checks waiting for lock, so every input pattern stays within these assumptions.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [2:0] {
    PH_RUN  = 3'd0,
    PH_PEND = 3'd1,
    PH_HK   = 3'd2,
    PH_DOWN = 3'd3,
    PH_WAKE = 3'd4
  } phase_t;

endpackage

// File: rtl/pwrdn_edge.sv
module pwrdn_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);

  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d = lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign rise_o = lvl_i & ~lvl_q;

  // R8: a level that was already high on the previous edge is not an edge
  a_r8_no_rise_on_level: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_i && $past(lvl_i) |-> !rise_o);

endmodule

// File: rtl/pwrdn_osc_timer.sv
module pwrdn_osc_timer #(
  parameter int unsigned OSC_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic skip_i,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CW = $clog2(OSC_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(OSC_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | (run_i & (cnt_q != '0));
    cnt_d  = cnt_q;
    if (load_i)      cnt_d = skip_i ? '0 : LOAD_VAL;
    else if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // R10: the wait counts down by exactly one per waking cycle
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !load_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
  import pwrdn_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pd_set_i,
  input  logic   pu_rise_i,
  input  logic   irq_ack_i,
  input  logic   rti_i,
  input  logic   idle_i,
  input  logic   pll_lock_i,
  input  logic   osc_done_i,
  input  logic   ctx_mode_i,
  output phase_t phase_o,
  output logic   wake_load_o,
  output logic   ctx_clr_o,
  output logic   resume_o
);

  phase_t st_q, st_d;
  logic   wake_done;
  logic   clr_q, clr_d, res_q, res_d;

  assign wake_done = (st_q == PH_WAKE) && osc_done_i && pll_lock_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PH_RUN:  if (pd_set_i) st_d = PH_PEND;
      PH_PEND: begin
        if (pu_rise_i)      st_d = PH_RUN;
        else if (irq_ack_i) st_d = PH_HK;
      end
      PH_HK: begin
        if (pu_rise_i || rti_i) st_d = PH_RUN;
        else if (idle_i)        st_d = PH_DOWN;
      end
      PH_DOWN: if (pu_rise_i) st_d = PH_WAKE;
      PH_WAKE: if (wake_done) st_d = PH_RUN;
      default: st_d = PH_RUN;
    endcase
  end

  always_comb begin
    clr_d = wake_done & ctx_mode_i;
    res_d = wake_done & ~ctx_mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_RUN;
      clr_q <= 1'b0;
      res_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      clr_q <= clr_d;
      res_q <= res_d;
    end
  end

  assign phase_o     = st_q;
  assign wake_load_o = (st_q == PH_DOWN) && pu_rise_i;
  assign ctx_clr_o   = clr_q;
  assign resume_o    = res_q;

  // R4: a second request while one is being serviced never re-enters pending
  a_r4_no_second_req: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == PH_HK && pd_set_i |=> st_q != PH_PEND);

  // R6: a power-up edge wins over idle during the handshake
  a_r6_abort_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_PEND || st_q == PH_HK) && pu_rise_i |=> st_q == PH_RUN);

  // R8: nothing but a power-up edge leaves the powered-down phase
  a_r8_down_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == PH_DOWN && !pu_rise_i |=> st_q == PH_DOWN);

  // R11: the two start-up pulses are exclusive
  a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_q && res_q));

endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_pkg::*;
#(
  parameter int unsigned OSC_CYC = 16,
  parameter int unsigned VEC_W   = 14,
  parameter logic [VEC_W-1:0] PD_VEC = 14'h002C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_set_i,
  input  logic             pu_bit_i,
  input  logic             irq_ack_i,
  input  logic             rti_i,
  input  logic             idle_i,
  input  logic             pll_lock_i,
  input  logic             xtal_on_i,
  input  logic             ctx_mode_i,
  output logic             nmi_req_o,
  output logic [VEC_W-1:0] nmi_vec_o,
  output logic             clk_en_o,
  output logic             osc_en_o,
  output logic             pll_en_o,
  output logic             hold_o,
  output logic             ctx_clr_o,
  output logic             resume_o,
  output logic [2:0]       phase_o
);

  phase_t ph;
  logic   pu_rise;
  logic   wake_load;
  logic   osc_done;
  logic   gated;

  pwrdn_edge u_pu_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (pu_bit_i),
    .rise_o (pu_rise)
  );

  pwrdn_osc_timer #(.OSC_CYC(OSC_CYC)) u_osc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (wake_load),
    .skip_i (xtal_on_i),
    .run_i  (ph == PH_WAKE),
    .done_o (osc_done)
  );

  pwrdn_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_set_i    (pd_set_i),
    .pu_rise_i   (pu_rise),
    .irq_ack_i   (irq_ack_i),
    .rti_i       (rti_i),
    .idle_i      (idle_i),
    .pll_lock_i  (pll_lock_i),
    .osc_done_i  (osc_done),
    .ctx_mode_i  (ctx_mode_i),
    .phase_o     (ph),
    .wake_load_o (wake_load),
    .ctx_clr_o   (ctx_clr_o),
    .resume_o    (resume_o)
  );

  assign gated     = (ph == PH_DOWN) || (ph == PH_WAKE);
  assign nmi_req_o = (ph == PH_PEND);
  assign nmi_vec_o = PD_VEC;
  assign clk_en_o  = ~gated;
  assign hold_o    = gated;
  assign pll_en_o  = (ph != PH_DOWN);
  assign osc_en_o  = (ph == PH_DOWN) ? xtal_on_i : 1'b1;
  assign phase_o   = ph;

  // R2: a request is only raised by a powerdown write
  a_r2_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req_o) |-> $past(pd_set_i));

  // R5: clocks stop only after an idle indication
  a_r5_gate_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_o) |-> $past(idle_i));

  // R10: clocks come back only with the PLL locked
  a_r10_lock_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en_o) |-> $past(pll_lock_i));

endmodule

// File: tb/tb_pwrdn_seq.sv
module tb_pwrdn_seq;

  localparam int OSC = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic pd_set, pu_bit, irq_ack, rti, idle, lock, xtal, mode;
  logic nmi, clk_en, osc_en, pll_en, hold, clr, res;
  logic [13:0] vec;
  logic [2:0]  phase;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pwrdn_seq #(.OSC_CYC(OSC)) dut (
    .clk(clk), .rst_n(rst_n), .pd_set_i(pd_set), .pu_bit_i(pu_bit),
    .irq_ack_i(irq_ack), .rti_i(rti), .idle_i(idle), .pll_lock_i(lock),
    .xtal_on_i(xtal), .ctx_mode_i(mode), .nmi_req_o(nmi), .nmi_vec_o(vec),
    .clk_en_o(clk_en), .osc_en_o(osc_en), .pll_en_o(pll_en), .hold_o(hold),
    .ctx_clr_o(clr), .resume_o(res), .phase_o(phase)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_pd();  pd_set = 1; tick(); pd_set = 0;  endtask
  task automatic pulse_ack(); irq_ack = 1; tick(); irq_ack = 0; endtask
  task automatic pulse_idle(); idle = 1; tick(); idle = 0; endtask

  task automatic pu_edge();
    pu_bit = 1; tick(); pu_bit = 0;
  endtask

  task automatic go_down();
    pulse_pd(); pulse_ack(); pulse_idle();
  endtask

  task automatic t_reset();
    chk("R1 phase", phase, 0);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 osc/pll", {osc_en, pll_en}, 3);
    chk("R1 nmi/hold/pulses", {nmi, hold, clr, res}, 0);
  endtask

  task automatic t_request();
    idle = 1; tick(); idle = 0;
    chk("R5 idle in run ignored", phase, 0);
    pulse_pd();
    chk("R2 phase pending", phase, 1);
    chk("R2 nmi", nmi, 1);
    chk("R2 vector", vec, 'h2C);
    tick(3);
    chk("R2 request held", nmi, 1);
    pulse_pd();
    chk("R4 pd in pending", phase, 1);
    pulse_idle();
    chk("R5 idle in pending ignored", phase, 1);
    pulse_ack();
    chk("R3 phase hk", phase, 2);
    chk("R3 nmi low", nmi, 0);
    pulse_pd();
    chk("R4 pd in hk", {phase, nmi}, {3'd2, 1'b0});
    rti = 1; tick(); rti = 0;
    chk("R7 rti abort", phase, 0);
  endtask

  task automatic t_abort();
    pulse_pd();
    pu_edge();
    chk("R6 abort from pending", {phase, nmi}, 0);
    tick();
    pulse_pd(); pulse_ack();
    pu_bit = 1; idle = 1; tick(); pu_bit = 0; idle = 0;
    chk("R6 abort beats idle", phase, 0);
    chk("R6 clocks on", clk_en, 1);
    tick();
  endtask

  task automatic t_down_wake(input logic x, input logic m);
    xtal = x; mode = m; lock = 1;
    go_down();
    chk("R5 phase down", phase, 3);
    chk("R5 gated", {clk_en, pll_en, hold}, 3'b001);
    chk("R8 osc follows xtal", osc_en, x);
    pulse_pd(); rti = 1; idle = 1; tick(); rti = 0; idle = 0;
    chk("R8 strobes ignored", phase, 3);
    pu_bit = 1; tick();
    chk("R9 waking", phase, 4);
    chk("R9 enables", {osc_en, pll_en, clk_en, hold}, 4'b1101);
    begin
      int cyc = 1;
      while (phase == 4 && cyc < 100) begin
        tick(); cyc++;
      end
      chk("R10 wake length", cyc - 1, x ? 1 : OSC + 1);
    end
    chk("R10 clocks back", clk_en, 1);
    chk("R11 ctx pulse", clr, m);
    chk("R11 resume pulse", res, !m);
    tick();
    chk("R11 pulse one cycle", {clr, res}, 0);
    tick(2);
    chk("R8 held pu no rewake", phase, 0);
    pu_bit = 0; tick();
  endtask

  task automatic t_lock_wait();
    xtal = 1; lock = 0;
    go_down();
    pu_edge();
    tick(5);
    chk("R10 waits for lock", phase, 4);
    lock = 1; tick();
    chk("R10 leaves on lock", phase, 0);
    tick();
  endtask

  initial begin
    rst_n = 0; pd_set = 0; pu_bit = 0; irq_ack = 0; rti = 0; idle = 0;
    lock = 1; xtal = 0; mode = 0;
    tick(3);
    rst_n = 1;
    tick();
    t_reset();
    t_request();
    t_abort();
    t_down_wake(1'b0, 1'b0);
    t_down_wake(1'b1, 1'b1);
    t_lock_wait();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule